// File: doc/BRIEF.md
# Paged ROM Table-Lookup Sequencer

This block carries out the table-lookup instruction of a small 4-bit processor core. When the core presents an instruction word whose upper five bits are `00100`, the sequencer takes the lower five bits as a page number. It joins that page with the 3-bit D register and the 4-bit accumulator to form a 12-bit program-ROM address. It then reads one 10-bit word from the synchronous ROM and writes the word back into the B and A registers. When the table-update mode flag is set, the word's two top bits also go into D.

While the ROM read is in progress, the current program counter is parked in one entry of the core's hardware return stack, and it is reloaded from that entry at the end. The stack array, its pointer and the A, B, D and PC registers all live in the core. The sequencer only drives their write strobes and write data and reads the stack entry it filled. The instruction takes three cycles. Busy is high for all three so the core stalls its fetch, and done pulses in the last one. The carry flag and the skip logic are never touched.

Top module: `tbl_lookup_seq`

## Requirements
- R1: A lookup starts only when `instr_valid` is high, `instr[9:5]` equals `00100` and the sequencer is idle. Any other opcode leaves `busy`, `rom_rd` and every write strobe low.
- R2: In the first cycle of a lookup (T1), `rom_rd` is high and `rom_addr` = {`instr[4:0]` in bits 11:7, `dreg_cur` in bits 6:4, `acc_cur` in bits 3:0}.
- R3: In T1 the PC is pushed. `sp_we` and `stk_we` are high, `sp_wdata` = `stk_waddr` = (`sp_cur` + 1) modulo DEPTH, and `stk_wdata` = `pc_cur`.
- R4: In the second cycle (T2), one cycle after the address, `b_we` and `a_we` are high with `b_wdata` = `rom_data[7:4]` and `a_wdata` = `rom_data[3:0]`.
- R5: In T2, if the mode flag was 1, `d_we` is high with `d_wdata` = {0, `rom_data[9]`, `rom_data[8]`}. If the flag was 0, `d_we` stays low and D keeps its value.
- R6: In the third cycle (T3), `stk_raddr` is the entry written in T1 and `pc_we` is high with `pc_wdata` = `stk_rdata`. `sp_we` restores the pointer to its value before T1, and `done` is high.
- R7: `busy` is high in T1, T2 and T3 and low otherwise. `instr_valid` during T2 or T3 starts nothing.
- R8: If `sp_cur` equals DEPTH-1 in T1, `stk_ovf` is high in that cycle only. The push wraps to entry 0 and the lookup still completes with the correct PC restored.
- R9: While reset is low and after it, until a lookup starts, `busy`, `done`, `rom_rd`, `stk_ovf` and every write strobe are low.
- R10: The mode flag `tbl_dwr_en` is sampled in T1. A change in T2 does not alter the D write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word valid this cycle |
| instr | input | 10 | Instruction word |
| tbl_dwr_en | input | 1 | Mode flag enabling the D write-back |
| acc_cur | input | 4 | Current accumulator A |
| dreg_cur | input | 3 | Current D register |
| pc_cur | input | 12 | Current program counter |
| sp_cur | input | SP_W | Current stack pointer |
| stk_rdata | input | 12 | Stack entry read at `stk_raddr` (asynchronous read) |
| rom_data | input | 10 | ROM word, valid the cycle after `rom_rd` |
| rom_rd | output | 1 | ROM read request |
| rom_addr | output | 12 | ROM read address |
| stk_we | output | 1 | Stack entry write |
| stk_waddr | output | SP_W | Stack entry written |
| stk_wdata | output | 12 | PC value pushed |
| stk_raddr | output | SP_W | Stack entry read |
| sp_we | output | 1 | Stack pointer write |
| sp_wdata | output | SP_W | New stack pointer |
| pc_we | output | 1 | PC write |
| pc_wdata | output | 12 | Restored PC |
| a_we | output | 1 | Accumulator write |
| a_wdata | output | 4 | New accumulator |
| b_we | output | 1 | B register write |
| b_wdata | output | 4 | New B |
| d_we | output | 1 | D register write |
| d_wdata | output | 3 | New D |
| stk_ovf | output | 1 | Lookup started on a full stack |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | Final lookup cycle |

## Verification
The address, the push and the overflow flag are due in the same cycle the opcode is presented, because they are combinational on the inputs in T1. The A, B and D writes are due one clock later, when the ROM model returns the word. The PC restore, the pointer restore and `done` come one clock after that. The register contents the core would hold are checked one clock later still. The bench drives each stimulus on a falling edge and reads the strobes a time unit later, so it inspects exactly one of T1, T2, T3 or the following idle cycle per step. It never compares against a later cycle than the one a result belongs to.

// File: rtl/lkp_pkg.sv
package lkp_pkg;
  localparam int OP_W   = 10;
  localparam int PAGE_W = 5;
  localparam int A_W    = 4;
  localparam int D_W    = 3;
  localparam int ROM_W  = 10;
  localparam int PC_W   = PAGE_W + D_W + A_W;
  localparam logic [OP_W-PAGE_W-1:0] LOOKUP_PREFIX = 5'b00100;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_RET  = 2'd2
  } lkp_st_e;

  function automatic logic is_lookup(input logic [OP_W-1:0] op);
    return op[OP_W-1:PAGE_W] == LOOKUP_PREFIX;
  endfunction

  function automatic logic [PC_W-1:0] table_addr(input logic [PAGE_W-1:0] page,
                                                  input logic [D_W-1:0] d,
                                                  input logic [A_W-1:0] a);
    return {page, d, a};
  endfunction

  function automatic logic [A_W-1:0] word_lo(input logic [ROM_W-1:0] w);
    return w[A_W-1:0];
  endfunction

  function automatic logic [A_W-1:0] word_hi(input logic [ROM_W-1:0] w);
    return w[2*A_W-1:A_W];
  endfunction

  function automatic logic [D_W-1:0] word_dval(input logic [ROM_W-1:0] w);
    return {1'b0, w[ROM_W-1:2*A_W]};
  endfunction
endpackage

// File: rtl/lkp_decode.sv
module lkp_decode
  import lkp_pkg::*;
(
  input  logic              instr_valid,
  input  logic [OP_W-1:0]   instr,
  input  logic              idle,
  output logic              hit,
  output logic [PAGE_W-1:0] page
);
  assign hit  = instr_valid && idle && is_lookup(instr);
  assign page = instr[PAGE_W-1:0];
endmodule

// File: rtl/lkp_ctrl.sv
module lkp_ctrl
  import lkp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic idle,
  output logic t1,
  output logic t2,
  output logic t3
);
  lkp_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (hit) st_d = ST_DATA;
      ST_DATA: st_d = ST_RET;
      ST_RET:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign idle = (st_q == ST_IDLE);
  assign t1   = hit;
  assign t2   = (st_q == ST_DATA);
  assign t3   = (st_q == ST_RET);
endmodule

// File: rtl/tbl_lookup_seq.sv
module tbl_lookup_seq
  import lkp_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [OP_W-1:0]   instr,
  input  logic              tbl_dwr_en,
  input  logic [A_W-1:0]    acc_cur,
  input  logic [D_W-1:0]    dreg_cur,
  input  logic [PC_W-1:0]   pc_cur,
  input  logic [SP_W-1:0]   sp_cur,
  input  logic [PC_W-1:0]   stk_rdata,
  input  logic [ROM_W-1:0]  rom_data,
  output logic              rom_rd,
  output logic [PC_W-1:0]   rom_addr,
  output logic              stk_we,
  output logic [SP_W-1:0]   stk_waddr,
  output logic [PC_W-1:0]   stk_wdata,
  output logic [SP_W-1:0]   stk_raddr,
  output logic              sp_we,
  output logic [SP_W-1:0]   sp_wdata,
  output logic              pc_we,
  output logic [PC_W-1:0]   pc_wdata,
  output logic              a_we,
  output logic [A_W-1:0]    a_wdata,
  output logic              b_we,
  output logic [A_W-1:0]    b_wdata,
  output logic              d_we,
  output logic [D_W-1:0]    d_wdata,
  output logic              stk_ovf,
  output logic              busy,
  output logic              done
);
  logic              idle, t1, t2, t3, hit;
  logic [PAGE_W-1:0] page;
  logic [SP_W-1:0]   push_idx, slot_q;
  logic              dwr_q;

  lkp_decode u_dec (
    .instr_valid (instr_valid),
    .instr       (instr),
    .idle        (idle),
    .hit         (hit),
    .page        (page)
  );

  lkp_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .idle  (idle),
    .t1    (t1),
    .t2    (t2),
    .t3    (t3)
  );

  assign push_idx = sp_cur + SP_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      dwr_q  <= 1'b0;
    end else if (t1) begin
      slot_q <= push_idx;
      dwr_q  <= tbl_dwr_en;
    end
  end

  // T1: address and push
  assign rom_rd    = t1;
  assign rom_addr  = table_addr(page, dreg_cur, acc_cur);
  assign stk_we    = t1;
  assign stk_waddr = push_idx;
  assign stk_wdata = pc_cur;
  assign stk_ovf   = t1 && (sp_cur == SP_W'(DEPTH - 1));

  // T2: register write-back
  assign a_we    = t2;
  assign a_wdata = word_lo(rom_data);
  assign b_we    = t2;
  assign b_wdata = word_hi(rom_data);
  assign d_we    = t2 && dwr_q;
  assign d_wdata = word_dval(rom_data);

  // T3: restore
  assign stk_raddr = slot_q;
  assign pc_we     = t3;
  assign pc_wdata  = stk_rdata;
  assign sp_we     = t1 || t3;
  assign sp_wdata  = t1 ? push_idx : slot_q - SP_W'(1);

  assign busy = t1 || t2 || t3;
  assign done = t3;
endmodule

// File: rtl/tbl_lookup_chk.sv
module tbl_lookup_chk
  import lkp_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rom_rd,
  input logic            stk_we,
  input logic [SP_W-1:0] stk_waddr,
  input logic [SP_W-1:0] sp_cur,
  input logic            sp_we,
  input logic [SP_W-1:0] sp_wdata,
  input logic            a_we,
  input logic            b_we,
  input logic            d_we,
  input logic [D_W-1:0]  d_wdata,
  input logic            pc_we,
  input logic            stk_ovf,
  input logic            busy,
  input logic            done
);
  // R4
  rd_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |=> (a_we && b_we));
  // R6
  write_then_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_we |=> (done && pc_we));
  // R6
  sp_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sp_we && sp_wdata == $past(sp_cur, 2)));
  // R3
  push_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |-> (sp_we && stk_waddr == sp_wdata));
  // R5
  d_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_we |-> (a_we && d_wdata[D_W-1] == 1'b0));
  // R8
  ovf_in_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |-> rom_rd);
  // R7
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_rd, a_we, pc_we}));
  // R7
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd || a_we || done) |-> busy);
endmodule

bind tbl_lookup_seq tbl_lookup_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rom_rd    (rom_rd),
  .stk_we    (stk_we),
  .stk_waddr (stk_waddr),
  .sp_cur    (sp_cur),
  .sp_we     (sp_we),
  .sp_wdata  (sp_wdata),
  .a_we      (a_we),
  .b_we      (b_we),
  .d_we      (d_we),
  .d_wdata   (d_wdata),
  .pc_we     (pc_we),
  .stk_ovf   (stk_ovf),
  .busy      (busy),
  .done      (done)
);

// File: tb/tbl_lookup_seq_tb.sv
module tbl_lookup_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int SPW = 3;
  localparam int NVEC = 6;
  // {page[5], a[4], d[3], mode[1], sp[3], pc[12]}
  localparam logic [27:0] VEC [NVEC] = '{
    {5'd0,  4'h0, 3'd0, 1'b1, 3'd0, 12'h123},
    {5'd31, 4'hF, 3'd7, 1'b1, 3'd2, 12'hABC},
    {5'd5,  4'h9, 3'd3, 1'b0, 3'd1, 12'h7FF},
    {5'd17, 4'h6, 3'd5, 1'b1, 3'd7, 12'h040},
    {5'd12, 4'hA, 3'd2, 1'b0, 3'd6, 12'hFFF},
    {5'd23, 4'h3, 3'd6, 1'b1, 3'd3, 12'h5A5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [9:0] instr = '0;
  logic tbl_dwr_en = 1'b0;
  logic ld_en = 1'b0;
  logic [3:0] ld_a = '0;
  logic [2:0] ld_d = '0;
  logic [SPW-1:0] ld_sp = '0;
  logic [11:0] ld_pc = '0;

  logic [3:0] reg_a = '0, reg_b = '0;
  logic [2:0] reg_d = '0;
  logic [SPW-1:0] reg_sp = '0;
  logic [11:0] reg_pc = '0;
  logic [11:0] stk [DEPTH];
  logic [9:0] rom_q = '0;

  logic rom_rd, stk_we, sp_we, pc_we, a_we, b_we, d_we, stk_ovf, busy, done;
  logic [11:0] rom_addr, stk_wdata, pc_wdata, stk_rdata;
  logic [SPW-1:0] stk_waddr, stk_raddr, sp_wdata;
  logic [3:0] a_wdata, b_wdata;
  logic [2:0] d_wdata;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [9:0] rom_fn(input logic [11:0] ad);
    logic [21:0] m;
    m = 22'(ad) * 22'd173;
    return m[9:0] ^ 10'h2A5;
  endfunction

  assign stk_rdata = stk[stk_raddr];

  always @(posedge clk) begin
    if (ld_en) begin
      reg_a <= ld_a; reg_d <= ld_d; reg_sp <= ld_sp; reg_pc <= ld_pc;
    end else begin
      if (a_we)  reg_a  <= a_wdata;
      if (b_we)  reg_b  <= b_wdata;
      if (d_we)  reg_d  <= d_wdata;
      if (sp_we) reg_sp <= sp_wdata;
      if (pc_we) reg_pc <= pc_wdata;
    end
    if (stk_we) stk[stk_waddr] <= stk_wdata;
    if (rom_rd) rom_q <= rom_fn(rom_addr);
  end

  tbl_lookup_seq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .tbl_dwr_en(tbl_dwr_en), .acc_cur(reg_a), .dreg_cur(reg_d), .pc_cur(reg_pc),
    .sp_cur(reg_sp), .stk_rdata(stk_rdata), .rom_data(rom_q),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .stk_we(stk_we), .stk_waddr(stk_waddr),
    .stk_wdata(stk_wdata), .stk_raddr(stk_raddr), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .a_we(a_we), .a_wdata(a_wdata),
    .b_we(b_we), .b_wdata(b_wdata), .d_we(d_we), .d_wdata(d_wdata),
    .stk_ovf(stk_ovf), .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [3:0] a, input logic [2:0] d,
                         input logic [SPW-1:0] s, input logic [11:0] pc);
    @(negedge clk);
    ld_en = 1'b1; ld_a = a; ld_d = d; ld_sp = s; ld_pc = pc;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_lookup(input logic [4:0] p, input logic [3:0] a, input logic [2:0] d,
                            input logic u, input logic [SPW-1:0] s, input logic [11:0] pc);
    logic [9:0] w;
    logic [SPW-1:0] slot;
    w = rom_fn({p, d, a});
    slot = s + 3'd1;
    preload(a, d, s, pc);
    instr_valid = 1'b1; instr = {5'b00100, p}; tbl_dwr_en = u;
    #1;
    check("R2 rom_rd", 32'(rom_rd), 32'd1);
    check("R2 rom_addr", 32'(rom_addr), 32'({p, d, a}));
    check("R3 push slot", 32'({stk_we, sp_we, stk_waddr, sp_wdata}), 32'({2'b11, slot, slot}));
    check("R3 push pc", 32'(stk_wdata), 32'(pc));
    check("R8 ovf", 32'(stk_ovf), 32'(s == 3'd7));
    check("R7 busy T1", 32'(busy), 32'd1);
    @(negedge clk);
    instr_valid = 1'b0; tbl_dwr_en = ~u;  // R10: flip after sampling
    #1;
    check("R4 a/b we", 32'({a_we, b_we}), 32'b11);
    check("R4 a/b data", 32'({b_wdata, a_wdata}), 32'(w[7:0]));
    check("R5 d_we", 32'(d_we), 32'(u));
    if (u) check("R5 d data", 32'(d_wdata), 32'({1'b0, w[9:8]}));
    check("R7 busy T2", 32'({busy, done}), 32'b10);
    @(negedge clk);
    #1;
    check("R6 done pc_we", 32'({done, pc_we, busy}), 32'b111);
    check("R6 raddr", 32'(stk_raddr), 32'(slot));
    check("R6 pc restore", 32'(pc_wdata), 32'(pc));
    check("R6 sp restore", 32'({sp_we, sp_wdata}), 32'({1'b1, s}));
    @(negedge clk);
    #1;
    check("R7 busy after", 32'({busy, done, rom_rd}), 32'd0);
    check("R4 regs B/A", 32'({reg_b, reg_a}), 32'(w[7:0]));
    check("R5 reg D", 32'(reg_d), u ? 32'({1'b0, w[9:8]}) : 32'(d));
    check("R6 regs PC/SP", 32'({reg_pc, reg_sp}), 32'({pc, s}));
    check("R8 stack entry", 32'(stk[slot]), 32'(pc));
    tbl_dwr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) stk[i] = 12'h000;
    repeat (3) @(negedge clk);
    #1;
    // R9 during reset
    check("R9 reset strobes", 32'({busy, done, rom_rd, stk_ovf, stk_we, sp_we, pc_we, a_we, b_we, d_we}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 idle after reset", 32'({busy, done, rom_rd, sp_we, pc_we}), 32'd0);

    for (int v = 0; v < NVEC; v++)
      run_lookup(VEC[v][27:23], VEC[v][22:19], VEC[v][18:16], VEC[v][15],
                 VEC[v][14:12], VEC[v][11:0]);

    // R1: other opcodes ignored
    preload(4'h5, 3'd2, 3'd1, 12'h321);
    instr_valid = 1'b1; instr = 10'h0A3;
    #1;
    check("R1 other opcode busy", 32'({busy, rom_rd, stk_we, sp_we}), 32'd0);
    @(negedge clk);
    instr = 10'h180;
    #1;
    check("R1 other opcode 2", 32'({busy, rom_rd}), 32'd0);
    @(negedge clk);
    instr_valid = 1'b0;
    #1;
    check("R1 state kept", 32'({reg_a, reg_d, reg_sp, busy}), 32'({4'h5, 3'd2, 3'd1, 1'b0}));

    // R1: valid low with lookup opcode
    instr = 10'h085;
    #1;
    check("R1 no valid", 32'(busy), 32'd0);

    // R7: instr_valid held during T2/T3 is ignored
    preload(4'h1, 3'd4, 3'd4, 12'h2B0);
    instr_valid = 1'b1; instr = 10'h08C;
    #1;
    check("R7 start", 32'(rom_rd), 32'd1);
    @(negedge clk);
    #1;
    check("R7 no restart T2", 32'({rom_rd, stk_we}), 32'd0);
    @(negedge clk);
    #1;
    check("R7 no restart T3", 32'({rom_rd, stk_we, done}), 32'b001);
    @(negedge clk);
    instr_valid = 1'b0;
    #1;
    check("R7 idle after", 32'({busy, reg_sp}), 32'({1'b0, 3'd4}));
    check("R7 single push", 32'(stk[5]), 32'h2B0);

    // R9: reset mid-lookup returns to idle
    preload(4'h2, 3'd1, 3'd0, 12'h111);
    instr_valid = 1'b1; instr = 10'h081;
    @(negedge clk);
    instr_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    check("R9 reset mid", 32'({busy, done, pc_we, a_we}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R9 idle after mid reset", 32'({busy, done}), 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule